// File: doc/BRIEF.md
# Transmit FIFO with Sticky Threshold Status Flag

This block is the byte queue that sits in front of a serial transmit shift register. It holds up to sixteen bytes. Two sources can push bytes into it: a host register port and a DMA-style write port that is marked as such. The shifter side pops bytes one at a time, taking the byte at the head of the queue. The block reports the current fill count in two forms: as a plain count, and placed in the upper byte of a 16-bit data-count word.

A programmable trigger level drives a sticky "room available" flag. The flag goes high when a pop leaves the queue at or below the trigger, and it stays high until it is cleared. Software clears it with a handshake. It first reads the flag while the flag is 1, then writes 0, and the clear only takes effect if the queue already holds more bytes than the trigger. A DMA push that takes the fill above the trigger clears the flag without any handshake. An interrupt request is raised while the flag is set and the transmit interrupt enable is high.

Top module: `txq_thresh_top`

## Requirements
- R1: Bytes leave through `tx_head` in the order they were accepted. `tx_avail` is 1 whenever the queue holds at least one byte, and a pop request on an empty queue changes nothing.
- R2: `fill_count` gives the number of stored bytes. `dcount_word` carries the same value in bits [12:8], with every other bit 0.
- R3: The queue holds at most 16 bytes. A push while it is full is dropped: the fill stays at 16 and the dropped byte never appears at `tx_head`.
- R4: `trig_sel` sets the trigger level: 2'b00 selects 8 bytes, 2'b01 selects 4, 2'b10 selects 2 and 2'b11 selects 0.
- R5: When a pop leaves the fill at or below the trigger level, `thr_flag` reads 1 from the next cycle on. A push alone never sets it.
- R6: On reset, `thr_flag` is 1, the fill is 0 and `tx_avail` is 0.
- R7: The host clear works as follows. A `flag_rd` strobe while `thr_flag` is 1 arms the clear. A later `flag_wr` with `flag_wdata` equal to 0, made while the fill exceeds the trigger, clears `thr_flag` on the next cycle.
- R8: Some writes leave `thr_flag` unchanged: writing 0 with no armed read, writing 1, and writing 0 while the fill is at or below the trigger. Any flag write uses up the arming.
- R9: An accepted DMA push that leaves the fill above the trigger clears `thr_flag` on the next cycle, with no read or write handshake.
- R10: Only one byte is accepted per cycle. When host and DMA pushes fall in the same cycle, the DMA byte is stored and the host byte is dropped.
- R11: When a pop that sets the flag and a host clear fall in the same cycle, the set wins and `thr_flag` stays 1.
- R12: `irq` is 1 exactly when `thr_flag` is 1 and `tie` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host push strobe |
| host_data | input | 8 | Host push byte |
| dma_wr | input | 1 | DMA push strobe |
| dma_data | input | 8 | DMA push byte |
| trig_sel | input | 2 | Trigger level select |
| tx_pop | input | 1 | Shifter pop request |
| tx_head | output | 8 | Byte at the head of the queue |
| tx_avail | output | 1 | Queue is not empty |
| flag_rd | input | 1 | Host read strobe of the status flag |
| flag_wr | input | 1 | Host write strobe of the status flag |
| flag_wdata | input | 1 | Value written to the status flag |
| tie | input | 1 | Transmit interrupt enable |
| fill_count | output | 5 | Number of stored bytes |
| dcount_word | output | 16 | Data-count word, fill in bits [12:8] |
| thr_flag | output | 1 | Sticky threshold flag |
| irq | output | 1 | Interrupt request |

## Verification
A pop that takes the fill down to the trigger can land in the same cycle as an armed host write of 0 while the fill is still one above the trigger. The bench sets this up at trigger 8 with nine bytes queued. It arms the clear with a read, then drives `tx_pop` and the zero write in the same cycle, and expects the flag to stay 1. Host and DMA pushes in the same cycle are also driven together. There the expected outcome is a fill of one with the DMA byte at the head.

// File: rtl/tff_pkg.sv
package tff_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        TRIG_8 = 2'b00,
        TRIG_4 = 2'b01,
        TRIG_2 = 2'b10,
        TRIG_0 = 2'b11
    } trig_sel_e;

    typedef struct packed {
        logic              valid;
        logic              from_dma;
        logic [BYTE_W-1:0] data;
    } push_req_t;

    function automatic int unsigned trig_level(trig_sel_e s);
        case (s)
            TRIG_8:  return 8;
            TRIG_4:  return 4;
            TRIG_2:  return 2;
            default: return 0;
        endcase
    endfunction

endpackage

// File: rtl/tff_arb.sv
module tff_arb
    import tff_pkg::*;
(
    input  logic              host_wr,
    input  logic [BYTE_W-1:0] host_data,
    input  logic              dma_wr,
    input  logic [BYTE_W-1:0] dma_data,
    output push_req_t         req
);
    // DMA source has priority; one byte per cycle
    always_comb begin
        req.valid    = host_wr | dma_wr;
        req.from_dma = dma_wr;
        req.data     = dma_wr ? dma_data : host_data;
    end
endmodule

// File: rtl/tff_store.sv
module tff_store #(
    parameter int DEPTH = 16,
    parameter int W     = 8,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push_v,
    input  logic [W-1:0]  push_d,
    input  logic          pop_req,
    output logic [W-1:0]  head,
    output logic [CW-1:0] fill,
    output logic [CW-1:0] fill_nxt,
    output logic          push_ok,
    output logic          pop_ok
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wptr, rptr;

    function automatic logic [PW-1:0] bump(logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    assign push_ok = push_v && (fill != CW'(DEPTH));
    assign pop_ok  = pop_req && (fill != '0);
    assign head    = mem[rptr];

    always_comb begin
        case ({push_ok, pop_ok})
            2'b10:   fill_nxt = fill + CW'(1);
            2'b01:   fill_nxt = fill - CW'(1);
            default: fill_nxt = fill;
        endcase
    end

    always_ff @(posedge clk) begin
        if (push_ok) mem[wptr] <= push_d;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr <= '0;
            rptr <= '0;
            fill <= '0;
        end else begin
            if (push_ok) wptr <= bump(wptr);
            if (pop_ok)  rptr <= bump(rptr);
            fill <= fill_nxt;
        end
    end
endmodule

// File: rtl/tff_flag.sv
module tff_flag #(
    parameter int CW = 5
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [CW-1:0] fill,
    input  logic [CW-1:0] fill_nxt,
    input  logic [CW-1:0] trig,
    input  logic          pop_ok,
    input  logic          dma_ok,
    input  logic          rd_stb,
    input  logic          wr_stb,
    input  logic          wr_bit,
    output logic          flag
);
    logic armed;
    logic set_ev, dma_clr, host_clr;

    assign set_ev   = pop_ok && (fill_nxt <= trig);
    assign dma_clr  = dma_ok && (fill_nxt > trig);
    assign host_clr = wr_stb && !wr_bit && armed && (fill > trig);

    always_ff @(posedge clk) begin
        if (rst) begin
            flag  <= 1'b1;
            armed <= 1'b0;
        end else begin
            if (set_ev)                   flag <= 1'b1;
            else if (dma_clr || host_clr) flag <= 1'b0;

            if (wr_stb || dma_clr)        armed <= 1'b0;
            else if (rd_stb && flag)      armed <= 1'b1;
        end
    end
endmodule

// File: rtl/txq_thresh_top.sv
module txq_thresh_top
    import tff_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_wr,
    input  logic [BYTE_W-1:0] host_data,
    input  logic              dma_wr,
    input  logic [BYTE_W-1:0] dma_data,
    input  logic [1:0]        trig_sel,
    input  logic              tx_pop,
    output logic [BYTE_W-1:0] tx_head,
    output logic              tx_avail,
    input  logic              flag_rd,
    input  logic              flag_wr,
    input  logic              flag_wdata,
    input  logic              tie,
    output logic [CW-1:0]     fill_count,
    output logic [15:0]       dcount_word,
    output logic              thr_flag,
    output logic              irq
);
    push_req_t     req;
    logic [CW-1:0] fill_nxt;
    logic [CW-1:0] trig_lvl;
    logic          push_ok, pop_ok;

    assign trig_lvl = CW'(trig_level(trig_sel_e'(trig_sel)));

    tff_arb u_arb (
        .host_wr   (host_wr),
        .host_data (host_data),
        .dma_wr    (dma_wr),
        .dma_data  (dma_data),
        .req       (req)
    );

    tff_store #(.DEPTH(DEPTH), .W(BYTE_W), .CW(CW)) u_store (
        .clk      (clk),
        .rst      (rst),
        .push_v   (req.valid),
        .push_d   (req.data),
        .pop_req  (tx_pop),
        .head     (tx_head),
        .fill     (fill_count),
        .fill_nxt (fill_nxt),
        .push_ok  (push_ok),
        .pop_ok   (pop_ok)
    );

    tff_flag #(.CW(CW)) u_flag (
        .clk      (clk),
        .rst      (rst),
        .fill     (fill_count),
        .fill_nxt (fill_nxt),
        .trig     (trig_lvl),
        .pop_ok   (pop_ok),
        .dma_ok   (push_ok && req.from_dma),
        .rd_stb   (flag_rd),
        .wr_stb   (flag_wr),
        .wr_bit   (flag_wdata),
        .flag     (thr_flag)
    );

    assign tx_avail    = (fill_count != '0);
    assign dcount_word = 16'(fill_count) << 8;
    assign irq         = thr_flag & tie;
endmodule

// File: rtl/tff_chk.sv
module tff_chk #(
    parameter int DEPTH = 16,
    parameter int CW    = 5
) (
    input logic          clk,
    input logic          rst,
    input logic          host_wr,
    input logic          dma_wr,
    input logic          tx_pop,
    input logic          tx_avail,
    input logic          flag_wr,
    input logic          flag_wdata,
    input logic          thr_flag,
    input logic [CW-1:0] fill,
    input logic [CW-1:0] trig
);
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
        fill <= CW'(DEPTH));

    // R1: fill moves by at most one byte per cycle
    p_fill_step_r1: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (fill == $past(fill) || fill == $past(fill) + CW'(1)
                         || fill + CW'(1) == $past(fill)));

    p_pop_sets_r5: assert property (@(posedge clk) disable iff (rst)
        (tx_pop && tx_avail && !host_wr && !dma_wr && (fill - CW'(1) <= trig))
        |=> thr_flag);

    p_rise_needs_pop_r5: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) && $rose(thr_flag) |-> $past(tx_pop));

    p_fall_cause_r8: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) && $fell(thr_flag) |-> $past(dma_wr || (flag_wr && !flag_wdata)));

    p_dma_clears_r9: assert property (@(posedge clk) disable iff (rst)
        (dma_wr && fill < CW'(DEPTH) && !tx_pop && (fill + CW'(1) > trig))
        |=> !thr_flag);
endmodule

bind txq_thresh_top tff_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .host_wr    (host_wr),
    .dma_wr     (dma_wr),
    .tx_pop     (tx_pop),
    .tx_avail   (tx_avail),
    .flag_wr    (flag_wr),
    .flag_wdata (flag_wdata),
    .thr_flag   (thr_flag),
    .fill       (fill_count),
    .trig       (trig_lvl)
);

// File: tb/sim_txq_thresh_top.sv
module sim_txq_thresh_top;
    localparam int CLK_NS = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_wr = 1'b0, dma_wr = 1'b0, tx_pop = 1'b0;
    logic [7:0]  host_data = '0, dma_data = '0;
    logic [1:0]  trig_sel = 2'b00;
    logic        flag_rd = 1'b0, flag_wr = 1'b0, flag_wdata = 1'b0, tie = 1'b0;
    logic [7:0]  tx_head;
    logic        tx_avail, thr_flag, irq;
    logic [4:0]  fill_count;
    logic [15:0] dcount_word;

    int checks = 0;
    int errors = 0;
    logic [7:0] q[$];

    always #(CLK_NS / 2) clk = ~clk;

    txq_thresh_top u0 (
        .clk(clk), .rst(rst),
        .host_wr(host_wr), .host_data(host_data),
        .dma_wr(dma_wr), .dma_data(dma_data),
        .trig_sel(trig_sel), .tx_pop(tx_pop),
        .tx_head(tx_head), .tx_avail(tx_avail),
        .flag_rd(flag_rd), .flag_wr(flag_wr), .flag_wdata(flag_wdata),
        .tie(tie), .fill_count(fill_count), .dcount_word(dcount_word),
        .thr_flag(thr_flag), .irq(irq)
    );

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // monitor: every accepted pop is compared against the scoreboard (R1)
    always @(negedge clk) begin
        if (!rst && tx_pop) begin
            if (q.size() == 0) chk("R1 avail on empty", int'(tx_avail), 0);
            else chk("R1 head order", int'(tx_head), int'(q.pop_front()));
        end
    end

    task automatic go();
        @(posedge clk); #1;
    endtask

    task automatic host_push(logic [7:0] b);
        go(); host_wr = 1'b1; host_data = b;
        if (q.size() < 16) q.push_back(b);
        go(); host_wr = 1'b0;
    endtask

    task automatic dma_push(logic [7:0] b);
        go(); dma_wr = 1'b1; dma_data = b;
        if (q.size() < 16) q.push_back(b);
        go(); dma_wr = 1'b0;
    endtask

    task automatic both_push(logic [7:0] h, logic [7:0] d);
        go(); host_wr = 1'b1; host_data = h; dma_wr = 1'b1; dma_data = d;
        if (q.size() < 16) q.push_back(d);
        go(); host_wr = 1'b0; dma_wr = 1'b0;
    endtask

    task automatic do_pop();
        go(); tx_pop = 1'b1;
        go(); tx_pop = 1'b0;
    endtask

    task automatic rd_flag();
        go(); flag_rd = 1'b1;
        go(); flag_rd = 1'b0;
    endtask

    task automatic wr_flag(logic v);
        go(); flag_wr = 1'b1; flag_wdata = v;
        go(); flag_wr = 1'b0;
    endtask

    task automatic look();
        @(negedge clk);
    endtask

    initial begin
        #(CLK_NS * 50000);
        $display("FAIL watchdog actual=running expected=finished");
        checks++; errors++;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;
        look();
        chk("R6 fill", int'(fill_count), 0);
        chk("R6 flag", int'(thr_flag), 1);
        chk("R6 avail", int'(tx_avail), 0);
        chk("R12 irq disabled", int'(irq), 0);
        tie = 1'b1;
        look();
        chk("R12 irq enabled", int'(irq), 1);

        do_pop(); look();
        chk("R1 pop empty fill", int'(fill_count), 0);

        // trigger 8 (R4 encoding 00)
        for (int i = 0; i < 10; i++) host_push(8'h10 + 8'(i));
        look();
        chk("R2 fill", int'(fill_count), 10);
        chk("R2 dcount word", int'(dcount_word), 10 << 8);
        chk("R5 push keeps flag", int'(thr_flag), 1);

        wr_flag(1'b0); look();
        chk("R8 write0 unarmed", int'(thr_flag), 1);
        rd_flag(); wr_flag(1'b1); look();
        chk("R8 write1", int'(thr_flag), 1);
        rd_flag(); wr_flag(1'b0); look();
        chk("R7 host clear", int'(thr_flag), 0);
        chk("R12 irq follows flag", int'(irq), 0);

        do_pop(); look();
        chk("R5 fill 9 above trig", int'(thr_flag), 0);
        do_pop(); look();
        chk("R5 fill 8 at trig", int'(thr_flag), 1);
        chk("R12 irq set", int'(irq), 1);

        trig_sel = 2'b01;
        rd_flag(); wr_flag(1'b0); look();
        chk("R4 trig4 clear", int'(thr_flag), 0);
        for (int i = 0; i < 3; i++) do_pop();
        look();
        chk("R4 trig4 fill5", int'(thr_flag), 0);
        do_pop(); look();
        chk("R4 trig4 fill4", int'(thr_flag), 1);

        trig_sel = 2'b10;
        rd_flag(); wr_flag(1'b0); look();
        chk("R4 trig2 clear", int'(thr_flag), 0);
        do_pop(); look();
        chk("R4 trig2 fill3", int'(thr_flag), 0);
        do_pop(); look();
        chk("R4 trig2 fill2", int'(thr_flag), 1);

        trig_sel = 2'b11;
        rd_flag(); wr_flag(1'b0); look();
        chk("R4 trig0 clear", int'(thr_flag), 0);
        do_pop(); look();
        chk("R4 trig0 fill1", int'(thr_flag), 0);
        do_pop(); look();
        chk("R4 trig0 fill0", int'(thr_flag), 1);

        trig_sel = 2'b00;
        rd_flag(); wr_flag(1'b0); look();
        chk("R8 write0 at or below trig", int'(thr_flag), 1);

        for (int i = 0; i < 8; i++) dma_push(8'h40 + 8'(i));
        look();
        chk("R9 dma fill 8 keeps flag", int'(thr_flag), 1);
        dma_push(8'h48); look();
        chk("R9 dma auto clear", int'(thr_flag), 0);
        chk("R9 fill", int'(fill_count), 9);

        do_pop(); look();
        chk("R5 back to 8", int'(thr_flag), 1);
        host_push(8'h60); look();
        chk("R11 setup fill", int'(fill_count), 9);
        rd_flag();
        go(); tx_pop = 1'b1; flag_wr = 1'b1; flag_wdata = 1'b0;
        go(); tx_pop = 1'b0; flag_wr = 1'b0;
        look();
        chk("R11 set wins", int'(thr_flag), 1);
        chk("R11 fill", int'(fill_count), 8);

        for (int i = 0; i < 8; i++) host_push(8'h70 + 8'(i));
        host_push(8'hEE); host_push(8'hEF);
        look();
        chk("R3 fill capped", int'(fill_count), 16);
        chk("R3 dcount word", int'(dcount_word), 16 << 8);
        for (int i = 0; i < 16; i++) do_pop();
        look();
        chk("R3 drained", int'(fill_count), 0);
        chk("R3 scoreboard empty", q.size(), 0);

        both_push(8'hAA, 8'h55); look();
        chk("R10 one accepted", int'(fill_count), 1);
        chk("R10 dma byte wins", int'(tx_head), 8'h55);
        do_pop(); look();
        chk("R10 drained", int'(fill_count), 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule